// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the processor-facing side of a programmable interrupt controller. A processor writes command bytes through a small bus made of a select, a write enable, a read enable, one address bit and an 8-bit data byte. After an initialization burst of two to four bytes, the block decodes three kinds of operation byte. It turns them into plain control outputs for the priority arbiter: the mask register, a one-cycle end-of-interrupt/rotate command with its fields, the special-mask mode flag, a one-cycle poll request, and the latched choice of status register to read.

Reads return the mask register, or one of the request or in-service registers that the arbiter supplies. The result is registered, so a read gives `rd_valid` and `rdata` one cycle later. The write side has no back-pressure: every cycle with `sel` and `wr_en` high is one accepted byte. The read side has no back-pressure either: every cycle with `sel` and `rd_en` high yields exactly one `rd_valid` beat in the next cycle.

Top module: `pic_cmd_regif`

## Requirements
- R1: After reset, `init_done`, `imr`, `smm`, `read_isr`, `cmd_stb` and `poll_stb` are all 0.
- R2: A write with `a0`=0 and data bit 4 = 1 is the first initialization byte, accepted at any time. It drops `init_done`, clears `imr`, `smm`, `read_isr` and `mode_cfg`, and sets `cascade_mode` to the inverse of data bit 1. Data bit 0 = 1 means a fourth byte will follow.
- R3: The next `a0`=1 write after the first byte loads `vec_base` with data bits 7..3.
- R4: In cascade mode only, the following `a0`=1 write loads `cascade_cfg` with the full byte.
- R5: The fourth byte is expected only when requested, and loads `mode_cfg`. `init_done` rises in the cycle after the last expected byte is written.
- R6: While `init_done` is 0, writes with `a0`=0 and data bit 4 = 0 have no effect. Before any first initialization byte, `a0`=1 writes also have no effect.
- R7: With `init_done`=1, an `a0`=1 write loads `imr` with the data byte.
- R8: With `init_done`=1, a write with `a0`=0 and data bits 4:3 = 00 pulses `cmd_stb` for one cycle in the next cycle. With it come `cmd_rotate` = bit 7, `cmd_specific` = bit 6, `cmd_eoi` = bit 5 and `cmd_level` = bits 2..0.
- R9: A write with `a0`=0 and data bits 4:3 = 01 is the mode/read-select byte. If its bit 6 is 1, `smm` takes bit 5. If its bit 6 is 0, `smm` is unchanged.
- R10: In that byte, bit 1 = 1 makes `read_isr` take bit 0. Bit 1 = 0 leaves `read_isr` latched as it was.
- R11: In that byte, bit 2 = 1 pulses `poll_stb` for one cycle in the next cycle.
- R12: A read (`sel`&`rd_en`) gives `rd_valid`=1 in the next cycle. `rdata` is then `imr` when `a0`=1; when `a0`=0 it is `isr` if `read_isr`=1, and `irr` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select |
| wr_en | input | 1 | Write this cycle (with sel) |
| rd_en | input | 1 | Read this cycle (with sel) |
| a0 | input | 1 | Address bit |
| wdata | input | 8 | Write data byte |
| irr | input | 8 | Request register from arbiter |
| isr | input | 8 | In-service register from arbiter |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| init_done | output | 1 | Initialization complete |
| vec_base | output | 5 | Vector base bits 7..3 |
| cascade_mode | output | 1 | 1 = cascade operation |
| cascade_cfg | output | 8 | Cascade configuration byte |
| mode_cfg | output | 8 | Fourth initialization byte, 0 if not sent |
| imr | output | 8 | Mask register |
| cmd_stb | output | 1 | End-of-interrupt/rotate command pulse |
| cmd_rotate | output | 1 | Rotate field |
| cmd_specific | output | 1 | Specific-level field |
| cmd_eoi | output | 1 | End-of-interrupt field |
| cmd_level | output | 3 | Level field |
| smm | output | 1 | Special mask mode |
| read_isr | output | 1 | 1 = status read returns in-service register |
| poll_stb | output | 1 | Poll request pulse |

## Verification
Most internal faults show up as a wrong sequencer state. Such a fault shows the cycle after the offending write: `init_done` rises too early or too late, or an `a0`=1 byte lands in the wrong configuration output or in `imr`. A wrong read-select latch appears on the next status read: `rdata` carries the request register where the in-service register was expected, or the reverse. Faulty strobe logic appears as a missing, stretched or premature `cmd_stb`/`poll_stb`, visible one cycle after the command byte.

// File: rtl/pic_regif_pkg.sv
package pic_regif_pkg;
  typedef enum logic [2:0] {
    W_NONE = 3'd0,
    W_ICW1 = 3'd1,
    W_DATA = 3'd2,
    W_OCW2 = 3'd3,
    W_OCW3 = 3'd4
  } wr_kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ICW2 = 3'd1,
    S_ICW3 = 3'd2,
    S_ICW4 = 3'd3,
    S_RUN  = 3'd4
  } init_st_e;
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_regif_pkg::*;
(
  input  logic       sel,
  input  logic       wr_en,
  input  logic       a0,
  input  logic [1:0] kind_bits,
  output wr_kind_e   kind
);
  always_comb begin
    kind = W_NONE;
    if (sel && wr_en) begin
      if (a0)                kind = W_DATA;
      else if (kind_bits[1]) kind = W_ICW1;
      else if (kind_bits[0]) kind = W_OCW3;
      else                   kind = W_OCW2;
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_regif_pkg::*;
#(
  parameter int DW = 8,
  localparam int VW = DW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_kind_e      kind,
  input  logic [DW-1:0] wdata,
  output logic          init_done,
  output logic [VW-1:0] vec_base,
  output logic          cascade_mode,
  output logic [DW-1:0] cascade_cfg,
  output logic [DW-1:0] mode_cfg
);
  init_st_e state;
  logic     need_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      need_last    <= 1'b0;
      vec_base     <= '0;
      cascade_mode <= 1'b0;
      cascade_cfg  <= '0;
      mode_cfg     <= '0;
    end else if (kind == W_ICW1) begin
      state        <= S_ICW2;
      cascade_mode <= ~wdata[1];
      need_last    <= wdata[0];
      mode_cfg     <= '0;
    end else if (kind == W_DATA) begin
      case (state)
        S_ICW2: begin
          vec_base <= wdata[DW-1:3];
          if (cascade_mode)   state <= S_ICW3;
          else if (need_last) state <= S_ICW4;
          else                state <= S_RUN;
        end
        S_ICW3: begin
          cascade_cfg <= wdata;
          state       <= need_last ? S_ICW4 : S_RUN;
        end
        S_ICW4: begin
          mode_cfg <= wdata;
          state    <= S_RUN;
        end
        default: state <= state;
      endcase
    end
  end

  assign init_done = (state == S_RUN);

  assert_init_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_done) |-> $past(kind == W_ICW1));

  assert_init_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(kind == W_DATA));
endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
  import pic_regif_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_kind_e      kind,
  input  logic          init_done,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] imr,
  output logic          cmd_stb,
  output logic          cmd_rotate,
  output logic          cmd_specific,
  output logic          cmd_eoi,
  output logic [LW-1:0] cmd_level,
  output logic          smm,
  output logic          read_isr,
  output logic          poll_stb
);
  logic run_ocw2, run_ocw3;
  assign run_ocw2 = init_done && (kind == W_OCW2);
  assign run_ocw3 = init_done && (kind == W_OCW3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr <= '0;
    end else if (kind == W_ICW1) begin
      imr <= '0;
    end else if (init_done && kind == W_DATA) begin
      imr <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_stb      <= 1'b0;
      cmd_rotate   <= 1'b0;
      cmd_specific <= 1'b0;
      cmd_eoi      <= 1'b0;
      cmd_level    <= '0;
    end else begin
      cmd_stb <= run_ocw2;
      if (run_ocw2) begin
        cmd_rotate   <= wdata[7];
        cmd_specific <= wdata[6];
        cmd_eoi      <= wdata[5];
        cmd_level    <= wdata[LW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smm      <= 1'b0;
      read_isr <= 1'b0;
      poll_stb <= 1'b0;
    end else if (kind == W_ICW1) begin
      smm      <= 1'b0;
      read_isr <= 1'b0;
      poll_stb <= 1'b0;
    end else begin
      poll_stb <= run_ocw3 && wdata[2];
      if (run_ocw3 && wdata[6]) smm      <= wdata[5];
      if (run_ocw3 && wdata[1]) read_isr <= wdata[0];
    end
  end

  assert_imr_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(imr) |-> $past(kind == W_ICW1 || (kind == W_DATA && init_done)));

  assert_cmd_needs_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(init_done));

  assert_smm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smm) |-> $past(kind == W_ICW1 || kind == W_OCW3));

  assert_poll_needs_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
    poll_stb |-> $past(init_done && kind == W_OCW3));
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          a0,
  input  logic          read_isr,
  input  logic [DW-1:0] imr,
  input  logic [DW-1:0] irr,
  input  logic [DW-1:0] isr,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        if (a0)            rdata <= imr;
        else if (read_isr) rdata <= isr;
        else               rdata <= irr;
      end
    end
  end

  assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_fire));
endmodule

// File: rtl/pic_cmd_regif.sv
module pic_cmd_regif
  import pic_regif_pkg::*;
#(
  parameter int DW = 8,
  localparam int VW = DW - 3,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] irr,
  input  logic [DW-1:0] isr,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic          init_done,
  output logic [VW-1:0] vec_base,
  output logic          cascade_mode,
  output logic [DW-1:0] cascade_cfg,
  output logic [DW-1:0] mode_cfg,
  output logic [DW-1:0] imr,
  output logic          cmd_stb,
  output logic          cmd_rotate,
  output logic          cmd_specific,
  output logic          cmd_eoi,
  output logic [LW-1:0] cmd_level,
  output logic          smm,
  output logic          read_isr,
  output logic          poll_stb
);
  wr_kind_e kind;

  pic_wr_decode u_dec (
    .sel       (sel),
    .wr_en     (wr_en),
    .a0        (a0),
    .kind_bits (wdata[4:3]),
    .kind      (kind)
  );

  pic_init_seq #(.DW(DW)) u_init (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (kind),
    .wdata        (wdata),
    .init_done    (init_done),
    .vec_base     (vec_base),
    .cascade_mode (cascade_mode),
    .cascade_cfg  (cascade_cfg),
    .mode_cfg     (mode_cfg)
  );

  pic_op_regs #(.DW(DW)) u_ops (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (kind),
    .init_done    (init_done),
    .wdata        (wdata),
    .imr          (imr),
    .cmd_stb      (cmd_stb),
    .cmd_rotate   (cmd_rotate),
    .cmd_specific (cmd_specific),
    .cmd_eoi      (cmd_eoi),
    .cmd_level    (cmd_level),
    .smm          (smm),
    .read_isr     (read_isr),
    .poll_stb     (poll_stb)
  );

  pic_rd_mux #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (sel && rd_en),
    .a0       (a0),
    .read_isr (read_isr),
    .imr      (imr),
    .irr      (irr),
    .isr      (isr),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );
endmodule

// File: tb/sim_pic_cmd_regif.sv
`timescale 1ns/1ps
module sim_pic_cmd_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, a0 = 1'b0;
  logic [7:0] wdata = '0, irr = '0, isr = '0;
  logic [7:0] rdata, cascade_cfg, mode_cfg, imr;
  logic [4:0] vec_base;
  logic [2:0] cmd_level;
  logic rd_valid, init_done, cascade_mode, cmd_stb, cmd_rotate, cmd_specific, cmd_eoi;
  logic smm, read_isr, poll_stb;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pic_cmd_regif u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
    .wdata(wdata), .irr(irr), .isr(isr), .rdata(rdata), .rd_valid(rd_valid),
    .init_done(init_done), .vec_base(vec_base), .cascade_mode(cascade_mode),
    .cascade_cfg(cascade_cfg), .mode_cfg(mode_cfg), .imr(imr), .cmd_stb(cmd_stb),
    .cmd_rotate(cmd_rotate), .cmd_specific(cmd_specific), .cmd_eoi(cmd_eoi),
    .cmd_level(cmd_level), .smm(smm), .read_isr(read_isr), .poll_stb(poll_stb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; a0 = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel = 1'b1; rd_en = 1'b1; a0 = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    sel = 1'b0; rd_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rd_valid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), {24'd0, rdata}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    irr = 8'h3C; isr = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 init_done", init_done, 0);
    check("R1 imr", imr, 0);
    check("R1 smm", smm, 0);
    check("R1 read_isr", read_isr, 0);
    check("R1 cmd_stb", cmd_stb, 0);
    check("R1 poll_stb", poll_stb, 0);

    // R6: nothing before first init byte
    wr(1'b0, 8'h20);
    check("R6 cmd_stb pre-init", cmd_stb, 0);
    wr(1'b1, 8'h55);
    check("R6 imr pre-init", imr, 0);
    check("R6 init_done pre-init", init_done, 0);

    // single mode, fourth byte requested
    wr(1'b0, 8'h13);
    check("R2 init_done low", init_done, 0);
    check("R2 cascade_mode single", cascade_mode, 0);
    wr(1'b1, 8'h48);
    check("R3 vec_base", vec_base, 5'h09);
    check("R5 waits for fourth byte", init_done, 0);
    wr(1'b0, 8'h68);
    check("R6 smm during init", smm, 0);
    check("R6 poll during init", poll_stb, 0);
    wr(1'b1, 8'h03);
    check("R5 mode_cfg", mode_cfg, 8'h03);
    check("R5 init_done", init_done, 1);

    wr(1'b1, 8'hA5);
    check("R7 imr", imr, 8'hA5);
    rd(1'b1, 8'hA5, "R12 read mask");
    rd(1'b0, 8'h3C, "R12 read request reg");

    wr(1'b0, 8'h0B);
    check("R10 read_isr set", read_isr, 1);
    rd(1'b0, 8'h81, "R12 read in-service reg");
    wr(1'b0, 8'h28);
    check("R10 read_isr held", read_isr, 1);
    check("R9 smm unchanged without enable", smm, 0);
    wr(1'b0, 8'h68);
    check("R9 smm set", smm, 1);
    wr(1'b0, 8'h48);
    check("R9 smm cleared", smm, 0);
    wr(1'b0, 8'h0C);
    check("R11 poll_stb pulse", poll_stb, 1);
    @(negedge clk);
    check("R11 poll_stb one cycle", poll_stb, 0);

    wr(1'b0, 8'h63);
    check("R8 cmd_stb", cmd_stb, 1);
    check("R8 fields", {cmd_rotate, cmd_specific, cmd_eoi, cmd_level}, 6'b011011);
    @(negedge clk);
    check("R8 cmd_stb one cycle", cmd_stb, 0);
    wr(1'b0, 8'hA0);
    check("R8 rotate fields", {cmd_stb, cmd_rotate, cmd_specific, cmd_eoi, cmd_level}, 7'b1101000);

    // restart: cascade, no fourth byte
    wr(1'b0, 8'h10);
    check("R2 restart init_done", init_done, 0);
    check("R2 restart imr", imr, 0);
    check("R2 restart read_isr", read_isr, 0);
    check("R2 cascade_mode", cascade_mode, 1);
    check("R2 mode_cfg cleared", mode_cfg, 0);
    wr(1'b1, 8'hF8);
    check("R3 vec_base cascade", vec_base, 5'h1F);
    check("R4 waits for cascade byte", init_done, 0);
    wr(1'b1, 8'h04);
    check("R4 cascade_cfg", cascade_cfg, 8'h04);
    check("R5 done without fourth byte", init_done, 1);
    check("R4 imr untouched by cascade byte", imr, 0);
    rd(1'b0, 8'h3C, "R12 read request after restart");

    repeat (3) @(negedge clk);
    check("R12 all reads returned", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule